// File: doc/BRIEF.md
# Unlockable Cartridge Command Register File

This block is a 32-bit memory-mapped register file for a cartridge-side controller. It stays hidden from the host bus until a two-word magic key has been written to a key register. While hidden, every read returns zero and every write other than a key write is dropped. Once opened, it presents a status word, two argument words and a fixed identifier word. A write to the status offset is taken as a one-character command that reads or changes configuration, selects byte-swap mode, loads a sector address, or hands a storage operation to an external engine.

Software loads the argument words first and then writes the command. Most commands finish in the cycle of the write. Storage commands (initialise, sector read, sector write) send a one-cycle start pulse to the engine, together with a copy of the arguments. The block then waits in a busy state until the engine returns a done pulse and a result code. That result code becomes the status word.

Two state machines do the work. The key sequencer has the states `KEY_IDLE` and `KEY_HALF`:
- `KEY_IDLE` goes to `KEY_HALF` on the first key word.
- `KEY_HALF` goes back to `KEY_IDLE` on the second key word, which also opens the block, or on any unrecognised word.

The command executor has the states `CMD_READY` and `CMD_WAIT`:
- `CMD_READY` goes to `CMD_WAIT` when a storage command is issued.
- `CMD_WAIT` goes back to `CMD_READY` when the engine's done pulse arrives.

Top module: `cart_cmd_regs`

## Requirements
- R1: Writing the masked value 0x5F554E4C to key offset 0x10 and then 0x4F434B5F opens the block. Repeating the first word while half-way keeps the sequence half-way, so first, first, second also opens the block.
- R2: Any key value other than the two key words and all-ones returns the sequence to idle. The second word written without a preceding first word does not open the block.
- R3: While the block is closed, every read returns 0. Writes to any offset except 0x10 are dropped: a data word written while closed still reads 0 after opening.
- R4: A read request returns data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. When open, offset 0x00 reads status, 0x04 reads arg0, 0x08 reads arg1 and 0x0C reads 0x53437632. Every other offset reads 0.
- R5: Each bit of `bus_be` enables one byte lane of the write data (bit n enables bits 8n+7..8n). Disabled lanes are written as zero.
- R6: Command 0x63 ('c') with arg0 = 1 copies the ROM-write-enable flag into arg1. With arg0 = 3 or 6 it writes 0 to arg1. Any other arg0 sets status to 0x40000000.
- R7: Command 0x43 ('C') with arg0 = 1 writes the old ROM-write-enable flag into arg1. It then sets the flag if arg1 was nonzero and clears it otherwise. Any other arg0 sets status to 0x40000000.
- R8: Command 0x69 ('i') acts on arg1:
  - 0: does nothing.
  - 4: sets `swap_mode`.
  - 5: clears `swap_mode`.
  - 1: starts an init request.
  - any other value: sets status to 0x40000000.
- R9: Command 0x49 ('I') loads the sector register from arg0. The loaded value is presented on `st_sector` with the next storage request.
- R10: Commands 0x73 ('s'), 0x53 ('S') and init raise `st_start` for exactly one cycle, in the cycle after the command write. `st_op` is 1 for init, 2 for read and 3 for write. `st_count` carries arg1 and `st_target` carries arg0. The cycle after `st_done`, status holds `st_result`. Command writes made while a request is outstanding are ignored.
- R11: Every accepted command write clears status first. An unrecognised command value sets status to 0x40000000.
- R12: Writing 0xFFFFFFFF to the key offset closes the block.
- R13: After reset the block is closed, the key sequence is idle, all registers are 0, both flags are 0 and `st_start` is low.
- R14: The byte-lane mask is applied before the key compare and the command decode. A key word written with a lane disabled does not count as that key word, and it resets the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| st_start | output | 1 | One-cycle storage request pulse |
| st_op | output | 2 | Storage operation: 1 init, 2 read, 3 write |
| st_sector | output | 32 | Sector address for the request |
| st_count | output | 32 | Sector count for the request (arg1) |
| st_target | output | 32 | Target buffer address for the request (arg0) |
| st_done | input | 1 | Engine completion pulse |
| st_result | input | 32 | Engine result code, latched into status |
| swap_mode | output | 1 | Byte-swap mode flag |
| rom_wr_en | output | 1 | ROM-write-enable flag |

## Verification
Register and flag writes take effect at the clock edge that samples the write, so they can be observed in the next cycle. Read data is registered and is due one edge after the request. The bench therefore drives every access on the falling edge and samples read data on the following falling edge. `st_start` and its arguments are due one edge after the command write and must fall again one edge later, and the bench checks both cycles. Status is due one edge after `st_done`. The bench checks it with a read issued after the done pulse, and before that it confirms that a command written during the wait left status and `st_start` unchanged.

// File: rtl/cart_cmd_pkg.sv
package cart_cmd_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam int OFS_STATUS = 'h00;
    localparam int OFS_ARG0   = 'h04;
    localparam int OFS_ARG1   = 'h08;
    localparam int OFS_IDENT  = 'h0C;
    localparam int OFS_KEY    = 'h10;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h5F55_4E4C;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h4F43_4B5F;
    localparam logic [DATA_W-1:0] KEY_CLOSE  = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] IDENT_WORD = 32'h5343_7632;
    localparam logic [DATA_W-1:0] STAT_ERROR = 32'h4000_0000;

    localparam logic [DATA_W-1:0] CMD_CFG_GET = 32'h63;
    localparam logic [DATA_W-1:0] CMD_CFG_SET = 32'h43;
    localparam logic [DATA_W-1:0] CMD_STORE   = 32'h69;
    localparam logic [DATA_W-1:0] CMD_SECTOR  = 32'h49;
    localparam logic [DATA_W-1:0] CMD_RD_SECT = 32'h73;
    localparam logic [DATA_W-1:0] CMD_WR_SECT = 32'h53;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INIT  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } st_op_e;

    typedef enum logic {
        KEY_IDLE = 1'b0,
        KEY_HALF = 1'b1
    } key_state_e;

    typedef enum logic {
        CMD_READY = 1'b0,
        CMD_WAIT  = 1'b1
    } cmd_state_e;
endpackage

// File: rtl/cart_key_seq.sv
module cart_key_seq
    import cart_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              unlocked
);
    key_state_e state_q, state_d;
    logic       open_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        open_d  = unlocked;
        if (key_wr) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (key_val == KEY_FIRST)
                        state_d = KEY_HALF;
                    else if (key_val == KEY_CLOSE)
                        open_d = 1'b0;
                end
                KEY_HALF: begin
                    if (key_val == KEY_SECOND) begin
                        state_d = KEY_IDLE;
                        open_d  = 1'b1;
                    end else if (key_val == KEY_CLOSE) begin
                        open_d = 1'b0;
                    end else if (key_val != KEY_FIRST) begin
                        state_d = KEY_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unlocked <= 1'b0;
        else        unlocked <= open_d;
    end
endmodule

// File: rtl/cart_cmd_exec.sv
module cart_cmd_exec
    import cart_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              arg0_wr,
    input  logic              arg1_wr,
    input  logic [DATA_W-1:0] wval,
    input  logic              st_done,
    input  logic [DATA_W-1:0] st_result,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] arg0,
    output logic [DATA_W-1:0] arg1,
    output logic              st_start,
    output logic [1:0]        st_op,
    output logic [DATA_W-1:0] st_sector,
    output logic [DATA_W-1:0] st_count,
    output logic [DATA_W-1:0] st_target,
    output logic              swap_mode,
    output logic              rom_wr_en
);
    cmd_state_e        state_q, state_d;
    logic [DATA_W-1:0] sector_q;
    logic              accept;
    logic              eng_cmd;

    assign accept  = cmd_wr && (state_q == CMD_READY);
    assign eng_cmd = (wval == CMD_RD_SECT) || (wval == CMD_WR_SECT) ||
                     ((wval == CMD_STORE) && (arg1 == DATA_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_READY: if (accept && eng_cmd) state_d = CMD_WAIT;
            CMD_WAIT:  if (st_done)           state_d = CMD_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status    <= '0;
            arg0      <= '0;
            arg1      <= '0;
            sector_q  <= '0;
            st_start  <= 1'b0;
            st_op     <= OP_NONE;
            st_sector <= '0;
            st_count  <= '0;
            st_target <= '0;
            swap_mode <= 1'b0;
            rom_wr_en <= 1'b0;
        end else begin
            st_start <= 1'b0;
            if (arg0_wr) arg0 <= wval;
            if (arg1_wr) arg1 <= wval;
            if (state_q == CMD_WAIT && st_done) status <= st_result;
            if (accept) begin
                status <= '0;
                if (eng_cmd) begin
                    st_start  <= 1'b1;
                    st_sector <= sector_q;
                    st_count  <= arg1;
                    st_target <= arg0;
                end
                unique case (wval)
                    CMD_CFG_GET: begin
                        if (arg0 == DATA_W'(1))
                            arg1 <= DATA_W'(rom_wr_en);
                        else if (arg0 == DATA_W'(3) || arg0 == DATA_W'(6))
                            arg1 <= '0;
                        else
                            status <= STAT_ERROR;
                    end
                    CMD_CFG_SET: begin
                        if (arg0 == DATA_W'(1)) begin
                            arg1      <= DATA_W'(rom_wr_en);
                            rom_wr_en <= (arg1 != '0);
                        end else begin
                            status <= STAT_ERROR;
                        end
                    end
                    CMD_STORE: begin
                        unique case (arg1)
                            DATA_W'(0): ;
                            DATA_W'(1): st_op <= OP_INIT;
                            DATA_W'(4): swap_mode <= 1'b1;
                            DATA_W'(5): swap_mode <= 1'b0;
                            default:    status <= STAT_ERROR;
                        endcase
                    end
                    CMD_SECTOR:  sector_q <= arg0;
                    CMD_RD_SECT: st_op <= OP_READ;
                    CMD_WR_SECT: st_op <= OP_WRITE;
                    default:     status <= STAT_ERROR;
                endcase
            end
        end
    end
endmodule

// File: rtl/cart_cmd_regs.sv
module cart_cmd_regs
    import cart_cmd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              st_start,
    output logic [1:0]        st_op,
    output logic [31:0]       st_sector,
    output logic [31:0]       st_count,
    output logic [31:0]       st_target,
    input  logic              st_done,
    input  logic [31:0]       st_result,
    output logic              swap_mode,
    output logic              rom_wr_en
);
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] masked;
    logic              unlocked;
    logic [DATA_W-1:0] status, arg0, arg1;
    logic [DATA_W-1:0] rd_mux;
    logic              hit_key, hit_cmd, hit_a0, hit_a1;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{bus_be[g]}};
    end

    assign masked  = bus_wdata & lane_mask;
    assign hit_key = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
    assign hit_cmd = bus_wr && unlocked && (bus_addr == ADDR_W'(OFS_STATUS));
    assign hit_a0  = bus_wr && unlocked && (bus_addr == ADDR_W'(OFS_ARG0));
    assign hit_a1  = bus_wr && unlocked && (bus_addr == ADDR_W'(OFS_ARG1));

    cart_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (hit_key),
        .key_val  (masked),
        .unlocked (unlocked)
    );

    cart_cmd_exec u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (hit_cmd),
        .arg0_wr   (hit_a0),
        .arg1_wr   (hit_a1),
        .wval      (masked),
        .st_done   (st_done),
        .st_result (st_result),
        .status    (status),
        .arg0      (arg0),
        .arg1      (arg1),
        .st_start  (st_start),
        .st_op     (st_op),
        .st_sector (st_sector),
        .st_count  (st_count),
        .st_target (st_target),
        .swap_mode (swap_mode),
        .rom_wr_en (rom_wr_en)
    );

    always_comb begin
        rd_mux = '0;
        if (unlocked) begin
            if      (bus_addr == ADDR_W'(OFS_STATUS)) rd_mux = status;
            else if (bus_addr == ADDR_W'(OFS_ARG0))   rd_mux = arg0;
            else if (bus_addr == ADDR_W'(OFS_ARG1))   rd_mux = arg1;
            else if (bus_addr == ADDR_W'(OFS_IDENT))  rd_mux = IDENT_WORD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/cart_cmd_regs_chk.sv
module cart_cmd_regs_chk
    import cart_cmd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] masked,
    input logic              unlocked,
    input logic [DATA_W-1:0] arg0,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              st_start
);
    assert_closed_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unlocked) |=> (bus_rdata == '0));

    assert_closed_write_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked && bus_addr != ADDR_W'(OFS_KEY)) |=> $stable(arg0));

    assert_ident_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unlocked && bus_addr == ADDR_W'(OFS_IDENT)) |=> (bus_rvalid && bus_rdata == IDENT_WORD));

    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_start |=> !st_start);

    assert_close_key_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_KEY) && masked == KEY_CLOSE) |=> !unlocked);
endmodule

bind cart_cmd_regs cart_cmd_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .masked     (masked),
    .unlocked   (unlocked),
    .arg0       (arg0),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .st_start   (st_start)
);

// File: tb/sim_cart_cmd_regs.sv
module sim_cart_cmd_regs;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;

    localparam logic [31:0] K1  = 32'h5F55_4E4C;
    localparam logic [31:0] K2  = 32'h4F43_4B5F;
    localparam logic [31:0] ID  = 32'h5343_7632;
    localparam logic [31:0] ERR = 32'h4000_0000;

    typedef struct packed {
        logic        rd;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'h00, 32'h0,    32'h0, 8'd3},  // R3 closed read
        '{1'b0, 5'h04, 32'h1234, 32'h0, 8'd3},  // R3 dropped write
        '{1'b0, 5'h10, K1,       32'h0, 8'd2},  // R2
        '{1'b0, 5'h10, 32'hDEAD_BEEF, 32'h0, 8'd2},
        '{1'b0, 5'h10, K2,       32'h0, 8'd2},
        '{1'b1, 5'h0C, 32'h0,    32'h0, 8'd2},  // R2 still closed
        '{1'b0, 5'h10, K2,       32'h0, 8'd2},
        '{1'b1, 5'h0C, 32'h0,    32'h0, 8'd2},  // R2 second word alone
        '{1'b0, 5'h10, K1,       32'h0, 8'd1},  // R1
        '{1'b0, 5'h10, K1,       32'h0, 8'd1},
        '{1'b0, 5'h10, K2,       32'h0, 8'd1},
        '{1'b1, 5'h0C, 32'h0,    ID,    8'd1},  // R1 open, R4 ident
        '{1'b1, 5'h04, 32'h0,    32'h0, 8'd3},  // R3 earlier write lost
        '{1'b1, 5'h14, 32'h0,    32'h0, 8'd4},  // R4 unmapped
        '{1'b0, 5'h04, 32'h1,    32'h0, 8'd6},  // R6
        '{1'b0, 5'h00, 32'h63,   32'h0, 8'd6},
        '{1'b1, 5'h08, 32'h0,    32'h0, 8'd6},
        '{1'b0, 5'h08, 32'h5,    32'h0, 8'd7},  // R7
        '{1'b0, 5'h00, 32'h43,   32'h0, 8'd7},
        '{1'b1, 5'h08, 32'h0,    32'h0, 8'd7},
        '{1'b0, 5'h00, 32'h63,   32'h0, 8'd6},
        '{1'b1, 5'h08, 32'h0,    32'h1, 8'd6},
        '{1'b0, 5'h08, 32'h0,    32'h0, 8'd7},
        '{1'b0, 5'h00, 32'h43,   32'h0, 8'd7},
        '{1'b1, 5'h08, 32'h0,    32'h1, 8'd7},
        '{1'b0, 5'h00, 32'h63,   32'h0, 8'd7},
        '{1'b1, 5'h08, 32'h0,    32'h0, 8'd7},
        '{1'b0, 5'h04, 32'h3,    32'h0, 8'd6},
        '{1'b0, 5'h08, 32'h9,    32'h0, 8'd6},
        '{1'b0, 5'h00, 32'h63,   32'h0, 8'd6},
        '{1'b1, 5'h08, 32'h0,    32'h0, 8'd6},
        '{1'b1, 5'h00, 32'h0,    32'h0, 8'd6},
        '{1'b0, 5'h04, 32'h2,    32'h0, 8'd6},
        '{1'b0, 5'h00, 32'h63,   32'h0, 8'd6},
        '{1'b1, 5'h00, 32'h0,    ERR,   8'd6},
        '{1'b0, 5'h00, 32'h43,   32'h0, 8'd7},
        '{1'b1, 5'h00, 32'h0,    ERR,   8'd7},
        '{1'b0, 5'h00, 32'h78,   32'h0, 8'd11}, // R11
        '{1'b1, 5'h00, 32'h0,    ERR,   8'd11},
        '{1'b0, 5'h04, 32'h1,    32'h0, 8'd11},
        '{1'b0, 5'h00, 32'h63,   32'h0, 8'd11},
        '{1'b1, 5'h00, 32'h0,    32'h0, 8'd11},
        '{1'b0, 5'h08, 32'h7,    32'h0, 8'd8},  // R8
        '{1'b0, 5'h00, 32'h69,   32'h0, 8'd8},
        '{1'b1, 5'h00, 32'h0,    ERR,   8'd8},
        '{1'b0, 5'h08, 32'h0,    32'h0, 8'd8},
        '{1'b0, 5'h00, 32'h69,   32'h0, 8'd8},
        '{1'b1, 5'h00, 32'h0,    32'h0, 8'd8},
        '{1'b1, 5'h04, 32'h0,    32'h1, 8'd4},  // R4 arg0 readback
        '{1'b1, 5'h08, 32'h0,    32'h0, 8'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [3:0]        bus_be = 4'hF;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              st_start;
    logic [1:0]        st_op;
    logic [31:0]       st_sector, st_count, st_target;
    logic              st_done = 1'b0;
    logic [31:0]       st_result = '0;
    logic              swap_mode, rom_wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_cmd_regs #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .st_start(st_start), .st_op(st_op), .st_sector(st_sector),
        .st_count(st_count), .st_target(st_target),
        .st_done(st_done), .st_result(st_result),
        .swap_mode(swap_mode), .rom_wr_en(rom_wr_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_valid_data();
    endtask

    function automatic logic [31:0] bus_valid_data();
        return bus_rvalid ? bus_rdata : 32'hBAD0_BAD0;
    endfunction

    task automatic done_pulse(input logic [31:0] res);
        @(negedge clk);
        st_done = 1'b1; st_result = res;
        @(negedge clk);
        st_done = 1'b0;
    endtask

    task automatic unlock();
        wr(5'h10, K1, 4'hF);
        wr(5'h10, K2, 4'hF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R10: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 rvalid", {31'b0, bus_rvalid}, 32'h0);
        check("R13 st_start", {31'b0, st_start}, 32'h0);
        check("R13 swap_mode", {31'b0, swap_mode}, 32'h0);
        check("R13 rom_wr_en", {31'b0, rom_wr_en}, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rd) begin
                rd(VEC[k].addr, d);
                check($sformatf("R%0d vec%0d", VEC[k].req, k), d, VEC[k].exp);
            end else begin
                wr(VEC[k].addr, VEC[k].data, 4'hF);
            end
        end

        // R5 byte lanes
        wr(5'h04, 32'hFFFF_FFFF, 4'b0101);
        rd(5'h04, d);
        check("R5 lanes", d, 32'h00FF_00FF);

        // R8 swap mode
        wr(5'h08, 32'h4, 4'hF);
        wr(5'h00, 32'h69, 4'hF);
        check("R8 swap set", {31'b0, swap_mode}, 32'h1);
        wr(5'h08, 32'h5, 4'hF);
        wr(5'h00, 32'h69, 4'hF);
        check("R8 swap clear", {31'b0, swap_mode}, 32'h0);

        // R9 / R10 sector read request
        wr(5'h04, 32'h77, 4'hF);
        wr(5'h00, 32'h49, 4'hF);
        wr(5'h04, 32'h1000, 4'hF);
        wr(5'h08, 32'h2, 4'hF);
        wr(5'h00, 32'h73, 4'hF);
        check("R10 start", {31'b0, st_start}, 32'h1);
        check("R10 op read", {30'b0, st_op}, 32'h2);
        check("R9 sector", st_sector, 32'h77);
        check("R10 count", st_count, 32'h2);
        check("R10 target", st_target, 32'h1000);
        @(negedge clk);
        check("R10 start drop", {31'b0, st_start}, 32'h0);
        wr(5'h00, 32'h78, 4'hF);
        check("R10 no restart", {31'b0, st_start}, 32'h0);
        rd(5'h00, d);
        check("R10 cmd ignored while busy", d, 32'h0);
        done_pulse(32'h0000_ABCD);
        rd(5'h00, d);
        check("R10 result latched", d, 32'h0000_ABCD);

        // R10 write and init requests
        wr(5'h00, 32'h53, 4'hF);
        check("R10 op write", {30'b0, st_op}, 32'h3);
        done_pulse(32'h0);
        wr(5'h08, 32'h1, 4'hF);
        wr(5'h00, 32'h69, 4'hF);
        check("R10 op init", {30'b0, st_op}, 32'h1);
        check("R10 init start", {31'b0, st_start}, 32'h1);
        done_pulse(ERR);
        rd(5'h00, d);
        check("R10 init result", d, ERR);

        // R12 close
        wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        rd(5'h0C, d);
        check("R12 closed", d, 32'h0);

        // R14 masked key
        wr(5'h10, K1, 4'b0111);
        wr(5'h10, K2, 4'hF);
        rd(5'h0C, d);
        check("R14 partial key", d, 32'h0);
        unlock();
        rd(5'h0C, d);
        check("R14 full key opens", d, ID);

        // R13 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(5'h0C, d);
        check("R13 closed after reset", d, 32'h0);
        unlock();
        rd(5'h04, d);
        check("R13 arg0 cleared", d, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule